// File: doc/BRIEF.md
# Nine-Step Move-Rotate-Merge Processor

This block is a very small 4-bit computer. It has a 16-word by 4-bit memory and a set of 4-bit working registers. It executes one kind of instruction only, so there is no opcode. Each instruction is four consecutive memory words: a source address, a destination address, a merge mask, and a word that is both the next instruction address and the rotate amount. The processor reads the source word, rotates it left by 0 to 3 places, and merges it into the destination word under the mask. It then writes the result back to the destination address.

There is no dedicated program counter. The address of the current instruction always lives in memory word 0. A fixed nine-step sequencer runs each instruction, one step per clock:

1. Fetch the instruction address from word 0.
2. Fetch the four instruction words.
3. Read both operands.
4. Write the merged result.
5. Store the next address back into word 0.

The surrounding logic loads a program through a preload port while the sequencer is idle. It starts execution either continuously (run level) or one instruction at a time (step request). It observes the step number, any working register and any memory word through registered debug outputs.

Top module: `mrm_core`

## Requirements
- R1: A synchronous reset returns the sequencer to step 0 (idle), clears every working register and clears the registered debug outputs; memory contents are not touched by reset.
- R2: From step 0, a high `run` or `step_req` moves to step 1. Steps 1 to 8 each advance by one per clock. After step 9 the sequencer goes to step 1 when `run` is high, otherwise back to step 0.
- R3: Step 1 reads memory word 0 into the instruction address register (debug code 7).
- R4: Steps 2 to 5 read addresses {IA[3:2], 00}, {IA[3:2], 01}, {IA[3:2], 10} and {IA[3:2], 11}, where IA is the instruction address register. The four words load, in that order, into the source-address register (code 5), the destination-address register (code 6), the mask register (code 2) and the next/rotate register (code 4).
- R5: Step 6 loads the memory word at the source address into the source-data register (code 0). Step 7 loads the word at the destination address into the destination-data register (code 3).
- R6: The source data is rotated left by one place when bit 0 of the next/rotate register is set, and by a further two places when bit 1 is set.
- R7: Step 8 writes the merged value to the memory word at the destination address. In each bit position, a mask bit of 1 selects the rotated source bit and a mask bit of 0 selects the destination-data bit.
- R8: Step 9 writes the whole next/rotate register into memory word 0.
- R9: When the source and destination addresses are equal, step 8 still uses the values latched in steps 6 and 7, so the result is the merge of the old word with its own rotation.
- R10: A preload write (`pre_we`) stores `pre_data` at `pre_addr` only while the sequencer is at step 0 and reset is low. At any other step the write is ignored.
- R11: `dbg_reg` shows, one clock later, the register selected by `dbg_sel`. Code 1 shows the merge value that step 8 would write.
- R12: `dbg_mem` shows, one clock later, the memory word at `pre_addr` as it stood before that clock edge's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep executing instructions back to back while high |
| step_req | input | 1 | Start one instruction from idle |
| pre_we | input | 1 | Preload write strobe, honoured only when idle |
| pre_addr | input | 4 | Preload write address, also the debug memory read address |
| pre_data | input | 4 | Preload write data |
| dbg_sel | input | 3 | Register code for the debug read |
| dbg_step | output | 4 | Current step, 0 = idle, 1..9 = executing |
| dbg_reg | output | 4 | Registered value of the selected register |
| dbg_mem | output | 4 | Registered memory word at `pre_addr` |

## Verification
The bench runs an instruction whose source and destination are the same word. A design that read memory during the write step, rather than using the latched operands, would store a rotation of an already-modified value there.

The bench uses nonzero rotate amounts of 1, 2 and 3. This catches a design that treats the rotate bits as a one-hot shift or shifts without wrapping; such a design would drop or misplace bits in the merged word.

Preload strobes are raised in the middle of an instruction. A design that did not gate them would corrupt the instruction words it had already fetched.

Continuous running is then stopped partway through an instruction. A sequencer that tested `run` at the wrong step would either stall mid-instruction or fail to stop at step 9.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_IA   = 4'd1,
    ST_W0   = 4'd2,
    ST_W1   = 4'd3,
    ST_W2   = 4'd4,
    ST_W3   = 4'd5,
    ST_SRC  = 4'd6,
    ST_DST  = 4'd7,
    ST_WB   = 4'd8,
    ST_NXT  = 4'd9
  } step_t;

  localparam int unsigned NREG = 8;

  // register codes, chosen so that each step maps to a fixed target
  localparam logic [2:0] RC_SD = 3'd0;  // source data
  localparam logic [2:0] RC_MG = 3'd1;  // merge value (not stored)
  localparam logic [2:0] RC_MK = 3'd2;  // mask
  localparam logic [2:0] RC_DD = 3'd3;  // destination data
  localparam logic [2:0] RC_NR = 3'd4;  // next address / rotate
  localparam logic [2:0] RC_SA = 3'd5;  // source address
  localparam logic [2:0] RC_DA = 3'd6;  // destination address
  localparam logic [2:0] RC_IA = 3'd7;  // instruction address

endpackage

// File: rtl/mrm_seq.sv
module mrm_seq
  import mrm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  step_req,
  output step_t step
);

  step_t step_n;

  always_comb begin
    step_n = step;
    case (step)
      ST_IDLE: if (run || step_req) step_n = ST_IA;
      ST_IA:   step_n = ST_W0;
      ST_W0:   step_n = ST_W1;
      ST_W1:   step_n = ST_W2;
      ST_W2:   step_n = ST_W3;
      ST_W3:   step_n = ST_SRC;
      ST_SRC:  step_n = ST_DST;
      ST_DST:  step_n = ST_WB;
      ST_WB:   step_n = ST_NXT;
      ST_NXT:  step_n = run ? ST_IA : ST_IDLE;
      default: step_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_IDLE;
    else     step <= step_n;
  end

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step != ST_IDLE && step != ST_NXT) |=> (step == 4'($past(step) + 4'd1)));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (step == ST_IDLE && (run || step_req)) |=> (step == ST_IA));

  p_halt_r2: assert property (@(posedge clk) disable iff (rst)
    (step == ST_NXT && !run) |=> (step == ST_IDLE));

endmodule

// File: rtl/mrm_mem.sv
module mrm_mem #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raddr,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] paddr,
  output logic [W-1:0] pdata
);

  localparam int unsigned DEPTH = 1 << W;

  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // execution port: same-cycle read so each step is one clock
  assign rdata = ram[raddr];

  // debug port: registered read, old data on a colliding write
  always_ff @(posedge clk) begin
    if (rst) pdata <= '0;
    else     pdata <= ram[paddr];
  end

endmodule

// File: rtl/mrm_dp.sv
module mrm_dp
  import mrm_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  step_t        step,
  input  logic [W-1:0] rd_data,
  input  logic [2:0]   dbg_sel,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic [W-1:0] dbg_reg
);

  localparam int unsigned IDXW = 2;             // four words per instruction
  localparam int unsigned ROTW = $clog2(W);     // rotate amount width

  logic [W-1:0] r_q [NREG];
  logic [W-1:0] merge;
  logic [W-1:0] rot;
  logic         ld_en;
  logic [2:0]   ld_code;
  logic [3:0]   idx_full;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v,
                                        input logic [ROTW-1:0] n);
    logic [2*W-1:0] d;
    d = {v, v} << n;
    return d[2*W-1:W];
  endfunction

  // step -> register target
  always_comb begin
    ld_en   = 1'b1;
    ld_code = RC_IA;
    case (step)
      ST_IA:   ld_code = RC_IA;
      ST_W0:   ld_code = RC_SA;
      ST_W1:   ld_code = RC_DA;
      ST_W2:   ld_code = RC_MK;
      ST_W3:   ld_code = RC_NR;
      ST_SRC:  ld_code = RC_SD;
      ST_DST:  ld_code = RC_DD;
      default: ld_en   = 1'b0;
    endcase
  end

  // address routing; word 0 when no source is selected
  assign idx_full = step - ST_W0;
  always_comb begin
    case (step)
      ST_W0, ST_W1, ST_W2, ST_W3:
        mem_addr = {r_q[RC_IA][W-1:IDXW], idx_full[IDXW-1:0]};
      ST_SRC:          mem_addr = r_q[RC_SA];
      ST_DST, ST_WB:   mem_addr = r_q[RC_DA];
      default:         mem_addr = '0;
    endcase
  end

  assign rot       = rotl(r_q[RC_SD], r_q[RC_NR][ROTW-1:0]);
  assign merge     = (rot & r_q[RC_MK]) | (r_q[RC_DD] & ~r_q[RC_MK]);
  assign mem_we    = (step == ST_WB) || (step == ST_NXT);
  assign mem_wdata = (step == ST_WB) ? merge : r_q[RC_NR];

  for (genvar c = 0; c < NREG; c++) begin : g_reg
    if (c == RC_MG) begin : g_merge
      assign r_q[c] = merge;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                 q <= '0;
        else if (ld_en && ld_code == 3'(c))      q <= rd_data;
      end
      assign r_q[c] = q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_reg <= '0;
    else     dbg_reg <= r_q[dbg_sel];
  end

  p_ia_load_r3: assert property (@(posedge clk) disable iff (rst)
    (step == ST_IA) |=> (r_q[RC_IA] == $past(rd_data)));

  p_fetch_seq_r4: assert property (@(posedge clk) disable iff (rst)
    (step == ST_W1 || step == ST_W2 || step == ST_W3)
      |-> (mem_addr == W'($past(mem_addr) + 1'b1)));

  p_keep_dst_r7: assert property (@(posedge clk) disable iff (rst)
    (step == ST_WB) |-> (((mem_wdata ^ r_q[RC_DD]) & ~r_q[RC_MK]) == '0));

  p_next_word0_r8: assert property (@(posedge clk) disable iff (rst)
    (step == ST_NXT) |-> (mem_we && mem_addr == '0 && mem_wdata == r_q[RC_NR]));

endmodule

// File: rtl/mrm_core.sv
module mrm_core
  import mrm_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step_req,
  input  logic         pre_we,
  input  logic [W-1:0] pre_addr,
  input  logic [W-1:0] pre_data,
  input  logic [2:0]   dbg_sel,
  output logic [3:0]   dbg_step,
  output logic [W-1:0] dbg_reg,
  output logic [W-1:0] dbg_mem
);

  step_t        step;
  logic [W-1:0] ex_addr;
  logic [W-1:0] ex_wdata;
  logic         ex_we;
  logic [W-1:0] rd_data;
  logic         pre_ok;
  logic         m_we;
  logic [W-1:0] m_waddr;
  logic [W-1:0] m_wdata;

  mrm_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .step_req (step_req),
    .step     (step)
  );

  mrm_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .rd_data   (rd_data),
    .dbg_sel   (dbg_sel),
    .mem_addr  (ex_addr),
    .mem_wdata (ex_wdata),
    .mem_we    (ex_we),
    .dbg_reg   (dbg_reg)
  );

  assign pre_ok  = pre_we && (step == ST_IDLE);
  assign m_we    = !rst && (ex_we || pre_ok);
  assign m_waddr = ex_we ? ex_addr  : pre_addr;
  assign m_wdata = ex_we ? ex_wdata : pre_data;

  mrm_mem #(.W(W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (m_we),
    .waddr (m_waddr),
    .wdata (m_wdata),
    .raddr (ex_addr),
    .rdata (rd_data),
    .paddr (pre_addr),
    .pdata (dbg_mem)
  );

  assign dbg_step = step;

  p_pre_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (m_we && !ex_we) |-> (step == ST_IDLE && pre_we));

endmodule

// File: tb/mrm_core_tb.sv
`timescale 1ns/1ps
module mrm_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       step_req = 1'b0;
  logic       pre_we = 1'b0;
  logic [3:0] pre_addr = '0;
  logic [3:0] pre_data = '0;
  logic [2:0] dbg_sel = '0;
  logic [3:0] dbg_step;
  logic [3:0] dbg_reg;
  logic [3:0] dbg_mem;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mrm_core #(.W(4)) dut_i (
    .clk(clk), .rst(rst), .run(run), .step_req(step_req),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .dbg_sel(dbg_sel), .dbg_step(dbg_step), .dbg_reg(dbg_reg), .dbg_mem(dbg_mem)
  );

  // behavioural reference model
  int m_mem [16];
  int m_reg [8];
  int m_step = 0;
  int e_step = 0, e_reg = 0, e_mem = 0;
  bit armed = 1'b0;

  function automatic int rot_l(int v, int n);
    return ((v << n) | (v >> (4 - n))) & 15;
  endfunction

  function automatic int merge_val();
    int r;
    r = rot_l(m_reg[0], m_reg[4] & 3);
    return (r & m_reg[2]) | (m_reg[3] & ~m_reg[2] & 15);
  endfunction

  function automatic int reg_view(int c);
    return (c == 1) ? merge_val() : m_reg[c];
  endfunction

  always @(posedge clk) begin
    int ia_blk;
    if (rst) begin
      e_reg = 0; e_mem = 0; m_step = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      e_reg = reg_view(dbg_sel);
      e_mem = m_mem[pre_addr];
      ia_blk = m_reg[7] & 12;
      case (m_step)
        0: if (pre_we) m_mem[pre_addr] = pre_data;
        1: m_reg[7] = m_mem[0];
        2: m_reg[5] = m_mem[ia_blk + 0];
        3: m_reg[6] = m_mem[ia_blk + 1];
        4: m_reg[2] = m_mem[ia_blk + 2];
        5: m_reg[4] = m_mem[ia_blk + 3];
        6: m_reg[0] = m_mem[m_reg[5]];
        7: m_reg[3] = m_mem[m_reg[6]];
        8: m_mem[m_reg[6]] = merge_val();
        9: m_mem[0] = m_reg[4];
        default: ;
      endcase
      if (m_step == 0)      m_step = (run || step_req) ? 1 : 0;
      else if (m_step == 9) m_step = run ? 1 : 0;
      else                  m_step = m_step + 1;
    end
    e_step = m_step;
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (dbg_step != e_step[3:0]) begin
        errors++;
        $display("FAIL R2 step actual=%0d expected=%0d t=%0t", dbg_step, e_step, $time);
      end
      checks++;
      if (dbg_reg != e_reg[3:0]) begin
        errors++;
        $display("FAIL R11 dbg_reg sel=%0d actual=%0d expected=%0d t=%0t", dbg_sel, dbg_reg, e_reg, $time);
      end
      checks++;
      if (dbg_mem != e_mem[3:0]) begin
        errors++;
        $display("FAIL R12 dbg_mem addr=%0d actual=%0d expected=%0d t=%0t", pre_addr, dbg_mem, e_mem, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic peek_reg(int code, int exp, string tag);
    dbg_sel = code[2:0];
    tick(1);
    check(tag, dbg_reg, exp);
  endtask

  task automatic peek_mem(int a, int exp, string tag);
    pre_addr = a[3:0];
    tick(1);
    check(tag, dbg_mem, exp);
  endtask

  task automatic load(int a, int d);
    pre_we = 1'b1; pre_addr = a[3:0]; pre_data = d[3:0];
    tick(1);
    pre_we = 1'b0;
  endtask

  task automatic one_step();
    step_req = 1'b1;
    tick(1);
    step_req = 1'b0;
    tick(10);
  endtask

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    check("R1 step after reset", dbg_step, 0);
    for (int c = 0; c < 8; c++) peek_reg(c, 0, "R1 register cleared");

    // program: clear memory, then instruction blocks at 4 and 8
    for (int a = 0; a < 16; a++) load(a, 0);
    load(0, 4);
    load(1, 4'b1001);
    load(3, 4'b0001);
    load(4, 1); load(5, 2); load(6, 4'b0110); load(7, 4'b1001);
    load(8, 3); load(9, 3); load(10, 4'b1111); load(11, 4'b1110);
    load(12, 1); load(13, 4); load(14, 4'b1000); load(15, 4'b0111);
    peek_mem(7, 9, "R10 preload while idle");

    // instruction 1, single step, rotate by 1
    one_step();
    check("R2 idle after single step", dbg_step, 0);
    peek_reg(7, 4, "R3 instruction address");
    peek_reg(5, 1, "R4 source address word");
    peek_reg(6, 2, "R4 destination address word");
    peek_reg(2, 6, "R4 mask word");
    peek_reg(4, 9, "R4 next/rotate word");
    peek_reg(0, 9, "R5 source data");
    peek_reg(3, 0, "R5 destination data");
    peek_reg(1, 2, "R6 rotated merge view");
    peek_mem(2, 2, "R7 merged write-back");
    peek_mem(0, 9, "R8 next address in word 0");

    // instruction 2: same source/destination, rotate by 2, preload attempts mid-run
    step_req = 1'b1;
    tick(1);
    step_req = 1'b0;
    tick(2);
    pre_we = 1'b1; pre_addr = 4'd5; pre_data = 4'hF;
    tick(3);
    pre_we = 1'b0;
    tick(6);
    check("R2 idle after second instruction", dbg_step, 0);
    peek_mem(3, 4, "R9 in-place rotate");
    peek_mem(5, 2, "R10 preload ignored while busy");
    peek_mem(0, 14, "R8 next address 14");

    // continuous running (rotate by 3 block at 12), then stop mid-instruction
    run = 1'b1;
    tick(40);
    run = 1'b0;
    tick(12);
    check("R2 stopped after run dropped", dbg_step, 0);
    for (int a = 0; a < 16; a++) peek_mem(a, m_mem[a], "R7 memory after run");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule